// File: doc/BRIEF.md
# FIFO Depth-Chaining Token Controller

This block is the ownership logic that lets several identical FIFO devices be wired into a ring and act as one deeper buffer. Each device watches a shared write strobe and a shared read strobe. It also watches the events that its own storage reports: the local pointers sitting on the last physical location, and the local full and empty flags. From these it decides whether this device currently holds the write token, the read token, both or neither. Local writes, local reads and the data output enable are gated by those tokens.

Tokens move between devices on a single active-low chaining line. When a device completes a write to its last location, it emits a one-cycle low pulse on its chaining output and gives up the write token. It emits another pulse when it completes a read of its last location, and then gives up the read token. Each chaining output drives the chaining input of the next device, and the last device feeds the first. A receiving device tells the two kinds of pulse apart by counting: the first pulse it receives grants the write token, the second grants the read token, and so on alternately.

The operating mode is captured from two strap pins while reset is asserted. In standalone/width mode the device always owns both tokens. The half-full pin then passes the local half-full flag and retransmit requests are forwarded. In chained mode the half-full pin carries the chaining output and retransmit is blocked. The storage array and the board-level OR of the per-device flags are outside this block.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While `rst_n` is low, the mode is taken from the straps: standalone (`mode_chain`=0) when `chain_in_n`=0 and `head_strap_n`=1; chained (`mode_chain`=1) for any other combination. After reset is released, the mode holds no matter what the strap pins do.
- R2: On leaving reset, `wr_own` and `rd_own` are both 1 in standalone mode. In chained mode both are 1 when `head_strap_n`=0 and both are 0 when `head_strap_n`=1.
- R3: The write enable `wr_en` = `wr_req` AND `wr_own` AND NOT `loc_full`, combinationally. The read enable `rd_en` and the output enable `q_oe` each = `rd_req` AND `rd_own` AND NOT `loc_empty`.
- R4: In chained mode, a completed write (`wr_en`=1) with `wr_at_last`=1 drives `chain_out_n` low for exactly the following cycle and clears `wr_own` from that cycle on.
- R5: In chained mode, a completed read (`rd_en`=1) with `rd_at_last`=1 drives `chain_out_n` low for exactly the following cycle and clears `rd_own` from that cycle on.
- R6: A write or read strobe at the last location that is not completed, because the device lacks the token or the local flag blocks it, produces no pulse and leaves the token unchanged.
- R7: In chained mode, each cycle with `chain_in_n`=0 counts as one received pulse. Received pulses alternately grant the write token and the read token, starting with write after reset. The grant is visible on `wr_own`/`rd_own` in the next cycle.
- R8: If a last-location write and a last-location read complete in the same cycle, the write pulse comes out first, in the next cycle. After one high cycle the read pulse follows, so `chain_out_n` reads 0,1,0,1 over the next four cycles.
- R9: `hf_pin_n` equals `half_full_n` in standalone mode and equals `chain_out_n` in chained mode. `rt_en` follows `rt_req` in standalone mode and is 0 in chained mode.
- R10: In standalone mode `chain_out_n` stays 1 even on last-location writes and reads, and `chain_in_n` has no effect on the tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| head_strap_n | input | 1 | Strap: low marks the device that starts with both tokens |
| chain_in_n | input | 1 | Active-low token pulse from the previous device (strap in standalone mode) |
| chain_out_n | output | 1 | Active-low one-cycle token pulse to the next device |
| wr_req | input | 1 | Shared write strobe |
| rd_req | input | 1 | Shared read strobe |
| loc_full | input | 1 | Local storage full |
| loc_empty | input | 1 | Local storage empty |
| wr_at_last | input | 1 | Local write pointer is at the last physical location |
| rd_at_last | input | 1 | Local read pointer is at the last physical location |
| half_full_n | input | 1 | Local active-low half-full flag |
| rt_req | input | 1 | Retransmit request |
| wr_en | output | 1 | Gated local write enable |
| rd_en | output | 1 | Gated local read enable |
| q_oe | output | 1 | Data output enable |
| wr_own | output | 1 | This device holds the write token |
| rd_own | output | 1 | This device holds the read token |
| mode_chain | output | 1 | 1 = chained mode, 0 = standalone/width mode |
| hf_pin_n | output | 1 | Half-full flag or chaining output, depending on mode |
| rt_en | output | 1 | Retransmit forwarded to storage |

## Verification
The main function is exercised with four patterns:
- A last-location write alone, and a last-location read alone. These separate the write handoff from the read handoff, and each shows its token dropping.
- Strobes that are blocked by a flag or by a missing token. These tell a completed handoff from an ignored one.
- A train of received pulses on a non-head device. This shows whether write and read grants alternate and restart with write once the write token has been passed on again.
- A write and a read that hit the last location together. This separates a correctly spaced pair of pulses from a merged one.

The same strobes are repeated in standalone mode to show that the chaining line stays quiet there.

// File: rtl/fce_pkg.sv
// Shared types for the FIFO chaining token controller.
// Assumes: mode straps are stable for at least one clock while reset is low.
package fce_pkg;
    typedef enum logic {
        MODE_ALONE = 1'b0,
        MODE_CHAIN = 1'b1
    } chain_mode_e;

    localparam int TOKEN_KINDS = 2;
    localparam int TOK_WR      = 0;
    localparam int TOK_RD      = 1;

    // Standalone only when the chaining input is tied low and head strap high.
    function automatic chain_mode_e decode_mode(input logic chain_in_n,
                                                input logic head_strap_n);
        return (!chain_in_n && head_strap_n) ? MODE_ALONE : MODE_CHAIN;
    endfunction
endpackage

// File: rtl/fce_mode_latch.sv
// Captures the operating mode from the strap pins while reset is held.
// Assumes: synchronous active-low reset; straps valid during reset.
module fce_mode_latch
    import fce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chain_in_n,
    input  logic        head_strap_n,
    output chain_mode_e mode_now,
    output chain_mode_e mode_q
);
    // Live decode of the straps, used for reset values elsewhere.
    always_comb mode_now = decode_mode(chain_in_n, head_strap_n);

    // Track straps during reset, freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_now;
    end

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/fce_pulse_track.sv
// Counts received chaining pulses and turns them into alternating
// write / read grants. Assumes each pulse is one clock cycle long.
module fce_pulse_track
    import fce_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  chain_mode_e            mode_q,
    input  logic                   chain_in_n,
    output logic [TOKEN_KINDS-1:0] grant
);
    logic next_is_rd;
    logic pulse_seen;

    // A low cycle on the input in chained mode is one received pulse.
    always_comb pulse_seen = (mode_q == MODE_CHAIN) && !chain_in_n;

    // Grant steering by parity of received pulses.
    always_comb begin
        grant         = '0;
        grant[TOK_WR] = pulse_seen && !next_is_rd;
        grant[TOK_RD] = pulse_seen &&  next_is_rd;
    end

    // Parity toggles on every received pulse, write first after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          next_is_rd <= 1'b0;
        else if (pulse_seen) next_is_rd <= !next_is_rd;
    end

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/fce_token_cell.sv
// Holds one token (write or read). Reset value depends on mode and head
// strap; in chained mode a grant sets it and a completed last-location
// access clears it. Assumes grant and release never coincide in use.
module fce_token_cell
    import fce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  chain_mode_e mode_now,
    input  chain_mode_e mode_q,
    input  logic        head_strap_n,
    input  logic        grant,
    input  logic        release_tok,
    output logic        own
);
    // Token register with mode-dependent reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 own <= (mode_now == MODE_ALONE) || !head_strap_n;
        else if (mode_q == MODE_CHAIN) begin
            if (grant)              own <= 1'b1;
            else if (release_tok)   own <= 1'b0;
        end
    end

    // R4 for the write copy, R5 for the read copy.
    p_token_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CHAIN && release_tok && !grant) |=> !own);
    p_alone_owns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ALONE) |-> own);
endmodule

// File: rtl/fce_xout_gen.sv
// Produces the active-low chaining output pulses. A same-cycle write and
// read handoff is split: write pulse first, read pulse GAP_CYCLES later.
module fce_xout_gen #(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hand,
    input  logic rd_hand,
    output logic chain_out_n
);
    localparam int PW = GAP_CYCLES + 1;
    localparam logic [PW-1:0] PEND_LOAD = PW'(1) << (PW - 1);

    logic [PW-1:0] pend_q;
    logic          fire;

    // Any handoff now, or a deferred read pulse reaching the end of the queue.
    always_comb fire = wr_hand || rd_hand || pend_q[0];

    // Output register and deferred-pulse shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_out_n <= 1'b1;
            pend_q      <= '0;
        end else begin
            chain_out_n <= !fire;
            pend_q      <= (wr_hand && rd_hand) ? PEND_LOAD : (pend_q >> 1);
        end
    end

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_out_n |=> chain_out_n);
endmodule

// File: rtl/fifo_chain_ctrl.sv
// Top of the FIFO chaining token controller. Gates local storage access by
// token ownership, passes tokens around a ring on an active-low pulse line,
// and muxes the half-full pin and retransmit by mode.
// Assumes: strobes are one cycle per access; storage reports flags and
// last-location status combinationally for the current pointers.
module fifo_chain_ctrl
    import fce_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_strap_n,
    input  logic chain_in_n,
    output logic chain_out_n,
    input  logic wr_req,
    input  logic rd_req,
    input  logic loc_full,
    input  logic loc_empty,
    input  logic wr_at_last,
    input  logic rd_at_last,
    input  logic half_full_n,
    input  logic rt_req,
    output logic wr_en,
    output logic rd_en,
    output logic q_oe,
    output logic wr_own,
    output logic rd_own,
    output logic mode_chain,
    output logic hf_pin_n,
    output logic rt_en
);
    chain_mode_e            mode_now, mode_q;
    logic [TOKEN_KINDS-1:0] grant;
    logic [TOKEN_KINDS-1:0] release_tok;
    logic [TOKEN_KINDS-1:0] own;
    logic                   wr_hand, rd_hand;

    fce_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .chain_in_n(chain_in_n),
        .head_strap_n(head_strap_n), .mode_now(mode_now), .mode_q(mode_q)
    );

    fce_pulse_track u_track (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
        .chain_in_n(chain_in_n), .grant(grant)
    );

    // Access gating by token and local flag.
    always_comb begin
        wr_en = wr_req && own[TOK_WR] && !loc_full;
        rd_en = rd_req && own[TOK_RD] && !loc_empty;
        q_oe  = rd_en;
    end

    // Handoff events only in chained mode and only on completed accesses.
    always_comb begin
        wr_hand = (mode_q == MODE_CHAIN) && wr_en && wr_at_last;
        rd_hand = (mode_q == MODE_CHAIN) && rd_en && rd_at_last;
        release_tok         = '0;
        release_tok[TOK_WR] = wr_hand;
        release_tok[TOK_RD] = rd_hand;
    end

    for (genvar k = 0; k < TOKEN_KINDS; k++) begin : g_tok
        fce_token_cell u_cell (
            .clk(clk), .rst_n(rst_n), .mode_now(mode_now), .mode_q(mode_q),
            .head_strap_n(head_strap_n), .grant(grant[k]),
            .release_tok(release_tok[k]), .own(own[k])
        );
    end

    fce_xout_gen #(.GAP_CYCLES(GAP_CYCLES)) u_xout (
        .clk(clk), .rst_n(rst_n), .wr_hand(wr_hand), .rd_hand(rd_hand),
        .chain_out_n(chain_out_n)
    );

    // Mode-dependent pin reuse and status outputs.
    always_comb begin
        wr_own     = own[TOK_WR];
        rd_own     = own[TOK_RD];
        mode_chain = (mode_q == MODE_CHAIN);
        hf_pin_n   = mode_chain ? chain_out_n : half_full_n;
        rt_en      = !mode_chain && rt_req;
    end

    p_alone_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chain |-> chain_out_n);
    p_grant_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant[TOK_WR] |=> wr_own);
    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_own |-> !wr_en);
    p_idle_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_own |-> !q_oe);
endmodule

// File: tb/fifo_chain_ctrl_bench.sv
module fifo_chain_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n, head_strap_n, chain_in_n, chain_out_n;
    logic wr_req, rd_req, loc_full, loc_empty, wr_at_last, rd_at_last;
    logic half_full_n, rt_req;
    logic wr_en, rd_en, q_oe, wr_own, rd_own, mode_chain, hf_pin_n, rt_en;
    int   total = 0;
    int   bad   = 0;
    logic done  = 1'b0;

    always #10 clk = ~clk;

    fifo_chain_ctrl u_fifo_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .head_strap_n(head_strap_n),
        .chain_in_n(chain_in_n), .chain_out_n(chain_out_n),
        .wr_req(wr_req), .rd_req(rd_req), .loc_full(loc_full),
        .loc_empty(loc_empty), .wr_at_last(wr_at_last), .rd_at_last(rd_at_last),
        .half_full_n(half_full_n), .rt_req(rt_req), .wr_en(wr_en),
        .rd_en(rd_en), .q_oe(q_oe), .wr_own(wr_own), .rd_own(rd_own),
        .mode_chain(mode_chain), .hf_pin_n(hf_pin_n), .rt_en(rt_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_req = 0; rd_req = 0; loc_full = 0; loc_empty = 0;
        wr_at_last = 0; rd_at_last = 0; half_full_n = 1; rt_req = 0;
    endtask

    task automatic do_reset(input logic cin, input logic head);
        @(negedge clk);
        idle_inputs();
        chain_in_n = cin; head_strap_n = head; rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic t_standalone();
        do_reset(1'b0, 1'b1);
        chk("R1 standalone mode", mode_chain, 1'b0);
        chk("R2 standalone wr_own", wr_own, 1'b1);
        chk("R2 standalone rd_own", rd_own, 1'b1);
        wr_req = 1; loc_full = 1; #1;
        chk("R3 write blocked by full", wr_en, 1'b0);
        loc_full = 0; #1;
        chk("R3 write passes", wr_en, 1'b1);
        rd_req = 1; loc_empty = 1; #1;
        chk("R3 read blocked by empty", q_oe, 1'b0);
        loc_empty = 0; #1;
        chk("R3 read passes", rd_en, 1'b1);
        chk("R3 output enable", q_oe, 1'b1);
        half_full_n = 0; rt_req = 1; #1;
        chk("R9 hf passes through", hf_pin_n, 1'b0);
        chk("R9 retransmit forwarded", rt_en, 1'b1);
        wr_at_last = 1; rd_at_last = 1;
        step();
        chk("R10 no pulse standalone", chain_out_n, 1'b1);
        step();
        chk("R10 no pulse standalone later", chain_out_n, 1'b1);
        idle_inputs();
        chain_in_n = 0; step(); chain_in_n = 1; step();
        chk("R10 chain input ignored wr", wr_own, 1'b1);
        chk("R10 chain input ignored rd", rd_own, 1'b1);
        chk("R1 mode held after strap change", mode_chain, 1'b0);
    endtask

    task automatic t_head_handoff();
        do_reset(1'b1, 1'b0);
        chk("R1 chained mode", mode_chain, 1'b1);
        chk("R2 head wr_own", wr_own, 1'b1);
        chk("R2 head rd_own", rd_own, 1'b1);
        half_full_n = 0; rt_req = 1; #1;
        chk("R9 hf pin shows chain out", hf_pin_n, 1'b1);
        chk("R9 retransmit blocked", rt_en, 1'b0);
        idle_inputs();
        wr_req = 1; step();
        chk("R4 non-last write no pulse", chain_out_n, 1'b1);
        chk("R4 non-last write keeps token", wr_own, 1'b1);
        wr_at_last = 1; loc_full = 1; step();
        chk("R6 blocked last write no pulse", chain_out_n, 1'b1);
        chk("R6 blocked last write keeps token", wr_own, 1'b1);
        loc_full = 0; step();
        wr_req = 0; wr_at_last = 0;
        chk("R4 write pulse low", chain_out_n, 1'b0);
        chk("R9 hf pin carries pulse", hf_pin_n, 1'b0);
        chk("R4 write token released", wr_own, 1'b0);
        chk("R4 read token kept", rd_own, 1'b1);
        step();
        chk("R4 pulse one cycle", chain_out_n, 1'b1);
        wr_req = 1; wr_at_last = 1; #1;
        chk("R3 no write without token", wr_en, 1'b0);
        step();
        chk("R6 tokenless write no pulse", chain_out_n, 1'b1);
        wr_req = 0; wr_at_last = 0;
        rd_req = 1; rd_at_last = 1; step();
        rd_req = 0; rd_at_last = 0;
        chk("R5 read pulse low", chain_out_n, 1'b0);
        chk("R5 read token released", rd_own, 1'b0);
        step();
        chk("R5 pulse one cycle", chain_out_n, 1'b1);
        rd_req = 1; #1;
        chk("R3 output released without token", q_oe, 1'b0);
        rd_req = 0;
    endtask

    task automatic t_receive();
        do_reset(1'b1, 1'b1);
        chk("R2 non-head wr_own", wr_own, 1'b0);
        chk("R2 non-head rd_own", rd_own, 1'b0);
        chain_in_n = 0; step(); chain_in_n = 1;
        chk("R7 first pulse grants write", wr_own, 1'b1);
        chk("R7 first pulse no read", rd_own, 1'b0);
        step();
        chain_in_n = 0; step(); chain_in_n = 1;
        chk("R7 second pulse grants read", rd_own, 1'b1);
        wr_req = 1; wr_at_last = 1; step();
        wr_req = 0; wr_at_last = 0;
        chk("R4 non-head write handoff", wr_own, 1'b0);
        step();
        chain_in_n = 0; step(); chain_in_n = 1;
        chk("R7 third pulse grants write again", wr_own, 1'b1);
    endtask

    task automatic t_same_cycle();
        do_reset(1'b1, 1'b0);
        wr_req = 1; rd_req = 1; wr_at_last = 1; rd_at_last = 1;
        step();
        idle_inputs();
        chk("R8 first pulse low", chain_out_n, 1'b0);
        step();
        chk("R8 gap high", chain_out_n, 1'b1);
        step();
        chk("R8 second pulse low", chain_out_n, 1'b0);
        step();
        chk("R8 back high", chain_out_n, 1'b1);
    endtask

    initial begin
        rst_n = 0; head_strap_n = 1; chain_in_n = 1;
        idle_inputs();
        t_standalone();
        t_head_handoff();
        t_receive();
        t_same_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule